// File: doc/BRIEF.md
# Debounced Level Interrupt Channel Bank

This block watches a bank of external input lines and turns each one into a clean, filtered level. It can also raise an interrupt from that level. Each line passes through a two-flop synchronizer and then a per-channel debounce filter. The filter's time base is a one-cycle millisecond tick supplied from outside the block. The filtered level is visible to software. When the channel is armed and the filtered level equals the channel's selected polarity, a latched status bit is set. Enabled status bits are combined into a single interrupt line.

Software reaches the block through a simple 32-bit register interface: a write strobe with address and data, plus a combinational read port. Arming is single-shot. The event that sets a status bit also consumes that channel's arm bit, so one stable level yields exactly one interrupt until software re-arms the channel. Edge behaviour is left to software, which flips the polarity after each event.

Top module: `deb_irq_bank`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is 0.
- R2: The filtered level of an enabled channel takes the synchronized input value on the N-th `ms_tick` during which the synchronized input differs from it. N is bits 11:0 of the channel's window register. It does not change before that tick, and it never changes in a cycle without a tick.
- R3: If the synchronized input returns to the filtered level before N ticks, the count restarts from zero, so a later change again needs N full ticks.
- R4: A window value of 0 behaves as a window of 1 tick.
- R5: While a channel's filter-enable bit (address 0x04, bit n) is 0, its filtered level (address 0x00, bit n) holds its value whatever the input does.
- R6: Raw status bit n (0x1C) is set when arm bit n (0x28) is 1 and the filtered level equals polarity bit n (0x14). Polarity 1 selects a high level and 0 selects a low level. When arm is 0 the bit is not set.
- R7: The event that sets raw status bit n also clears arm bit n. After the status is acknowledged, the bit is not set again until arm n is written 1, even if the level still matches.
- R8: Writing 1 to bit n of the acknowledge register (0x24) clears raw status bit n. Writing 0 has no effect. The acknowledge register reads 0.
- R9: Pending status (0x20) is raw status AND interrupt enable (0x18), and `irq` is 1 exactly when any pending bit is 1.
- R10: Writing 0 to an arm bit while its raw status bit is set leaves the status bit set.
- R11: Channel n's window register is at 0x40 + 4n and reads back only bits 11:0. Bitmask registers read back only bits 7:0 (channel n is bit n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ch_in | input | 8 | Asynchronous external inputs, one per channel |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined level interrupt |

## Verification
The filter is exercised three ways:
- A clean input change held for exactly the window shows where the update falls, at the last tick and not one tick early.
- A glitch shorter than the window, followed by a fresh change, separates a counter that restarts from one that only pauses.
- A zero window and a disabled channel cover the edges of the filter's configuration.

The event path is then driven with a level that matches the polarity while the channel is unarmed, armed, acknowledged and re-armed. It is checked under both polarities and with the enable both masking and passing the status. This shows whether the arm gate, the single-shot consumption and the write-one-to-clear acknowledge behave independently of each other.

// File: rtl/deb_irq_pkg.sv
package deb_irq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_LEVEL = 8'h00;
    localparam logic [ADDR_W-1:0] A_FEN   = 8'h04;
    localparam logic [ADDR_W-1:0] A_POL   = 8'h14;
    localparam logic [ADDR_W-1:0] A_IEN   = 8'h18;
    localparam logic [ADDR_W-1:0] A_RAW   = 8'h1C;
    localparam logic [ADDR_W-1:0] A_PEND  = 8'h20;
    localparam logic [ADDR_W-1:0] A_ACK   = 8'h24;
    localparam logic [ADDR_W-1:0] A_ARM   = 8'h28;
    localparam int                A_WIN0  = 'h40;
    localparam int                WIN_STEP = 4;
endpackage

// File: rtl/deb_irq_filter.sv
module deb_irq_filter #(
    parameter int DBW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pin_i,
    input  logic           tick_i,
    input  logic           en_i,
    input  logic [DBW-1:0] win_i,
    output logic           stable_o
);
    typedef struct packed {
        logic           s1;
        logic           s2;
        logic           stable;
        logic [DBW-1:0] cnt;
    } flt_t;

    flt_t           d, q;
    logic [DBW-1:0] lim;
    logic [DBW:0]   cnt_inc;

    always_comb begin
        lim     = (win_i == '0) ? DBW'(1) : win_i;
        cnt_inc = {1'b0, q.cnt} + 1'b1;
        d       = q;
        d.s1    = pin_i;
        d.s2    = q.s1;
        if (!en_i) begin
            d.cnt = '0;
        end else if (q.s2 == q.stable) begin
            d.cnt = '0;
        end else if (tick_i) begin
            if (cnt_inc >= {1'b0, lim}) begin
                d.stable = q.s2;
                d.cnt    = '0;
            end else begin
                d.cnt = cnt_inc[DBW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stable_o = q.stable;

    AST_LEVEL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(stable_o)); // R2
    AST_LEVEL_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(stable_o)); // R5
    AST_COUNT_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.cnt == '0)); // R5
endmodule

// File: rtl/deb_irq_event.sv
module deb_irq_event #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] level_i,
    input  logic [NCH-1:0] pol_i,
    input  logic           arm_wr_i,
    input  logic [NCH-1:0] arm_wdata_i,
    input  logic           ack_wr_i,
    input  logic [NCH-1:0] ack_wdata_i,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] arm_o
);
    typedef struct packed {
        logic [NCH-1:0] raw;
        logic [NCH-1:0] arm;
    } evt_t;

    evt_t           d, q;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] ack_bits;
    logic [NCH-1:0] arm_next;

    always_comb begin
        hit      = q.arm & ~(level_i ^ pol_i);
        ack_bits = ack_wr_i ? ack_wdata_i : '0;
        arm_next = arm_wr_i ? arm_wdata_i : q.arm;
        d.raw    = (q.raw & ~ack_bits) | hit;
        d.arm    = arm_next & ~hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raw_o = q.raw;
    assign arm_o = q.arm;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_RAW_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.raw[i]) |-> $past(q.arm[i])); // R6
        AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.raw[i]) |-> !q.arm[i]); // R7
        AST_RAW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (q.raw[i] && !(ack_wr_i && ack_wdata_i[i])) |=> q.raw[i]); // R10
    end
endmodule

// File: rtl/deb_irq_bank.sv
module deb_irq_bank
    import deb_irq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DBW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic [NCH-1:0]    ch_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic [NCH-1:0]          fen;
        logic [NCH-1:0]          pol;
        logic [NCH-1:0]          ien;
        logic [NCH-1:0][DBW-1:0] win;
    } regs_t;

    regs_t          d, q;
    logic [NCH-1:0] level;
    logic [NCH-1:0] raw;
    logic [NCH-1:0] arm;
    logic [NCH-1:0] pend;
    logic           arm_wr;
    logic           ack_wr;
    logic           unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DBW];

    always_comb begin
        d = q;
        if (bus_wr) begin
            case (bus_addr)
                A_FEN:   d.fen = bus_wdata[NCH-1:0];
                A_POL:   d.pol = bus_wdata[NCH-1:0];
                A_IEN:   d.ien = bus_wdata[NCH-1:0];
                default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == ADDR_W'(A_WIN0 + WIN_STEP * i))
                    d.win[i] = bus_wdata[DBW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        deb_irq_filter #(.DBW(DBW)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (ch_in[i]),
            .tick_i   (ms_tick),
            .en_i     (q.fen[i]),
            .win_i    (q.win[i]),
            .stable_o (level[i])
        );
    end

    assign arm_wr = bus_wr && (bus_addr == A_ARM);
    assign ack_wr = bus_wr && (bus_addr == A_ACK);

    deb_irq_event #(.NCH(NCH)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_i     (level),
        .pol_i       (q.pol),
        .arm_wr_i    (arm_wr),
        .arm_wdata_i (bus_wdata[NCH-1:0]),
        .ack_wr_i    (ack_wr),
        .ack_wdata_i (bus_wdata[NCH-1:0]),
        .raw_o       (raw),
        .arm_o       (arm)
    );

    assign pend = raw & q.ien;
    assign irq  = |pend;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_LEVEL: bus_rdata[NCH-1:0] = level;
            A_FEN:   bus_rdata[NCH-1:0] = q.fen;
            A_POL:   bus_rdata[NCH-1:0] = q.pol;
            A_IEN:   bus_rdata[NCH-1:0] = q.ien;
            A_RAW:   bus_rdata[NCH-1:0] = raw;
            A_PEND:  bus_rdata[NCH-1:0] = pend;
            A_ARM:   bus_rdata[NCH-1:0] = arm;
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(A_WIN0 + WIN_STEP * i))
                bus_rdata[DBW-1:0] = q.win[i];
        end
    end

    AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ien == '0) |-> !irq); // R9
    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != '0)); // R9
    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ACK) |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/deb_irq_bank_tb.sv
module deb_irq_bank_tb;
    import deb_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic [7:0]  ch_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #4 clk = ~clk;

    deb_irq_bank u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ch_in(ch_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic        is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q_exp[$];
    logic  mon_req = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // monitor: samples two ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_req && q_exp.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q_exp.pop_front();
                act = it.is_irq ? {31'd0, irq} : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%02h actual=%08h expected=%08h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] v, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = v; it.tag = tag;
        q_exp.push_back(it);
        mon_req = 1'b1;
        @(negedge clk);
        mon_req = 1'b0;
    endtask

    task automatic expect_irq(input logic v, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'd0, v}; it.tag = tag;
        q_exp.push_back(it);
        mon_req = 1'b1;
        @(negedge clk);
        mon_req = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        expect_reg(A_LEVEL, 32'h0, "R1 level");
        expect_reg(A_FEN, 32'h0, "R1 fen");
        expect_reg(A_RAW, 32'h0, "R1 raw");
        expect_reg(A_ARM, 32'h0, "R1 arm");
        expect_reg(8'h40, 32'h0, "R1 win0");
        expect_irq(1'b0, "R1 irq");
        // R11 field widths
        wr(8'h5C, 32'hFFFF_FFFF);
        expect_reg(8'h5C, 32'h0000_0FFF, "R11 win7");
        wr(A_FEN, 32'hFFFF_FFFF);
        expect_reg(A_FEN, 32'h0000_00FF, "R11 fen");
        wr(8'h40, 32'd3);
        expect_reg(8'h40, 32'd3, "R11 win0");
        // R2 exact window
        ch_in[0] = 1'b1; idle(3);
        ticks(2);
        expect_reg(A_LEVEL, 32'h00, "R2 early");
        ticks(1);
        expect_reg(A_LEVEL, 32'h01, "R2 on time");
        // R3 glitch restarts count
        ch_in[0] = 1'b0; idle(3);
        ticks(2);
        ch_in[0] = 1'b1; idle(3);
        expect_reg(A_LEVEL, 32'h01, "R3 glitch");
        ch_in[0] = 1'b0; idle(3);
        ticks(2);
        expect_reg(A_LEVEL, 32'h01, "R3 restarted");
        ticks(1);
        expect_reg(A_LEVEL, 32'h00, "R3 full window");
        // R4 zero window acts as one
        ch_in[1] = 1'b1; idle(3);
        ticks(1);
        expect_reg(A_LEVEL, 32'h02, "R4 zero window");
        // R5 disabled channel frozen
        wr(A_FEN, 32'hFD);
        ch_in[1] = 1'b0; idle(3);
        ticks(3);
        expect_reg(A_LEVEL, 32'h02, "R5 frozen");
        wr(A_FEN, 32'hFF);
        ticks(1);
        expect_reg(A_LEVEL, 32'h00, "R5 reenabled");
        // R6 arm and polarity gating
        wr(A_POL, 32'hFF);
        wr(A_IEN, 32'hFF);
        wr(A_ARM, 32'h01);
        idle(2);
        expect_reg(A_RAW, 32'h00, "R6 no match");
        expect_reg(A_ARM, 32'h01, "R6 arm kept");
        ch_in[2] = 1'b1; idle(3);
        ticks(1); idle(2);
        expect_reg(A_LEVEL, 32'h04, "R6 ch2 level");
        expect_reg(A_RAW, 32'h00, "R6 unarmed");
        ch_in[0] = 1'b1; idle(3);
        ticks(3); idle(2);
        expect_reg(A_RAW, 32'h01, "R6 high event");
        expect_reg(A_ARM, 32'h00, "R7 arm consumed");
        expect_reg(A_PEND, 32'h01, "R9 pend");
        expect_irq(1'b1, "R9 irq on");
        // R8 acknowledge
        wr(A_ACK, 32'h00); idle(1);
        expect_reg(A_RAW, 32'h01, "R8 zero write");
        expect_reg(A_ACK, 32'h00, "R8 reads zero");
        wr(A_ACK, 32'h01); idle(2);
        expect_reg(A_RAW, 32'h00, "R7 no retrigger");
        expect_irq(1'b0, "R8 irq off");
        // R9 enable masking
        wr(A_ARM, 32'h01); idle(2);
        expect_reg(A_RAW, 32'h01, "R7 rearmed");
        wr(A_IEN, 32'hFE);
        expect_reg(A_PEND, 32'h00, "R9 masked pend");
        expect_irq(1'b0, "R9 masked irq");
        wr(A_IEN, 32'hFF);
        expect_irq(1'b1, "R9 unmasked irq");
        // R10 disarm leaves status
        wr(A_ARM, 32'h10); idle(2);
        wr(A_ARM, 32'h00); idle(2);
        expect_reg(A_RAW, 32'h01, "R10 raw kept");
        expect_reg(A_ARM, 32'h00, "R10 arm cleared");
        // R6 low polarity
        wr(A_POL, 32'hF7);
        wr(A_ARM, 32'h08); idle(2);
        expect_reg(A_RAW, 32'h09, "R6 low event");
        wr(A_ACK, 32'hFF); idle(2);
        expect_reg(A_RAW, 32'h00, "R8 all cleared");
        expect_irq(1'b0, "R9 irq idle");
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule